// File: doc/BRIEF.md
# Debug Monitor Mode Entry Controller

This controller decides, once per reset, whether the device boots into normal user operation or into a debug monitor session. It looks at the mode conditions on the first clock edge after reset is released and keeps that decision until the next reset. Monitor mode is entered in two ways. In the first, a high-voltage level is detected on the interrupt pin while the mode pins carry the required pattern. In the second, no high voltage is needed: both bytes of the reset vector read from flash are erased (all ones).

For the rest of the session the controller maps the reset, break and software-interrupt vector fetches into a separate page. It also produces a registered select that tells the external glitch-free clock switch whether to divide the oscillator by two or to pass it straight through. Finally, it produces the watchdog enable. In monitor mode the watchdog stays off until the high voltage goes away. A configuration disable bit can force the watchdog off in any mode.

Top module: `monitor_entry_ctrl`

## Requirements
- R1: With `hv_irq` high and `mode_pins` equal to 2'b10 at the capture edge, `mon_mode` becomes 1.
- R2: With `rv_hi` and `rv_lo` both 8'hFF at the capture edge, `mon_mode` becomes 1 whatever the high-voltage and mode-pin inputs are. If only one byte is 8'hFF, this path does not apply.
- R3: If neither entry condition holds at the capture edge, `mon_mode` becomes 0 (user mode). This includes `hv_irq` high with `mode_pins` other than 2'b10.
- R4: The decision is taken on the first rising clock edge with `rst_n` high. Before that edge, `mon_mode` reads 0. Pin changes after that edge do not affect `mon_mode` or `clk_bypass` until the next reset.
- R5: While `rst_n` is low, `mon_mode`, `clk_bypass` and `cop_en` are all 0, with asynchronous effect.
- R6: In monitor mode, `fetch_addr` 16'hFFFE maps to 16'hFEFE on `vec_addr`, and 16'hFFFF maps to 16'hFEFF. In user mode both pass through unchanged.
- R7: In monitor mode, 16'hFFFC maps to 16'hFEFC and 16'hFFFD maps to 16'hFEFD. In user mode both pass through unchanged.
- R8: Any `fetch_addr` outside 16'hFFFC..16'hFFFF appears unchanged on `vec_addr` in both modes.
- R9: `clk_bypass` is 1 only when monitor mode is entered with `clk_sel` low at the capture edge. In every other case it is 0, meaning divide by two.
- R10: After capture with `cop_dis` low, `cop_en` is 1 in user mode. In monitor mode it is 0 while the high voltage is still present, or when monitor mode was entered without high voltage.
- R11: If monitor mode was entered with high voltage present (`hv_irq` or `hv_rst` high), `cop_en` rises on the first clock edge at which both `hv_irq` and `hv_rst` are low. It then stays 1 until reset, even if the high voltage returns.
- R12: `cop_dis` high forces `cop_en` to 0 immediately in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hv_irq | input | 1 | High-voltage detected on the interrupt pin |
| hv_rst | input | 1 | High-voltage detected on the reset pin |
| mode_pins | input | 2 | Mode-select pin levels |
| clk_sel | input | 1 | Clock-select pin; low requests divider bypass |
| rv_hi | input | 8 | Reset-vector high byte read from flash |
| rv_lo | input | 8 | Reset-vector low byte read from flash |
| cop_dis | input | 1 | Configuration bit that disables the watchdog |
| fetch_addr | input | 16 | Address of the current fetch |
| mon_mode | output | 1 | 1 = monitor mode, 0 = user mode |
| vec_addr | output | 16 | Fetch address after vector remap |
| clk_bypass | output | 1 | 1 = bus clock equals oscillator, 0 = oscillator / 2 |
| cop_en | output | 1 | Watchdog enable |

## Verification
A wrong mode decision shows up one edge after reset release in three places at once: `mon_mode`, `cop_en` and the remapped vector for 16'hFFFE. The bench therefore checks all three for every entry pattern. A capture register that keeps sampling instead of holding shows up only after the pins change, so the hold test changes every input after capture and reads the outputs again several cycles later. A fault in the sticky high-voltage-loss flag shows up one edge after the voltage drops, or when the voltage returns. For that reason `cop_en` is sampled before the drop, one cycle after it, and again after the voltage is restored.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

    // Captured boot decision
    typedef struct packed {
        logic done;      // decision has been taken
        logic mon;       // monitor mode selected
        logic bypass;    // divide-by-two bypass selected
        logic hv_entry;  // high voltage was present at entry
    } boot_st;

    // Watchdog control state
    typedef struct packed {
        logic hv_lost;   // high voltage removed during a monitor session
    } cop_st;

endpackage

// File: rtl/mon_mode_sampler.sv
module mon_mode_sampler
    import mon_entry_pkg::*;
#(
    parameter int                MODE_W     = 2,
    parameter logic [MODE_W-1:0] MODE_MATCH = 2'b10,
    parameter int                DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_irq,
    input  logic              hv_present,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              clk_sel,
    input  logic [DATA_W-1:0] rv_hi,
    input  logic [DATA_W-1:0] rv_lo,
    output logic              done,
    output logic              mon,
    output logic              bypass,
    output logic              hv_entry
);

    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    boot_st s_d, s_q;
    logic   hv_path;
    logic   erased_path;
    logic   enter_mon;

    always_comb begin
        hv_path     = hv_irq && (mode_pins == MODE_MATCH);
        erased_path = (rv_hi == ERASED) && (rv_lo == ERASED);
        enter_mon   = hv_path || erased_path;

        s_d = s_q;
        if (!s_q.done) begin
            s_d.done     = 1'b1;
            s_d.mon      = enter_mon;
            s_d.bypass   = enter_mon && !clk_sel;
            s_d.hv_entry = enter_mon && hv_present;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign done     = s_q.done;
    assign mon      = s_q.mon;
    assign bypass   = s_q.bypass;
    assign hv_entry = s_q.hv_entry;

    AST_MODE_HELD:    assert property (@(posedge clk) disable iff (!rst_n)
                          s_q.done |=> ($stable(s_q.mon) && $stable(s_q.bypass))); // R4
    AST_BYPASS_IN_MON: assert property (@(posedge clk) disable iff (!rst_n)
                          s_q.bypass |-> s_q.mon); // R9
    AST_DONE_STICKY:  assert property (@(posedge clk) disable iff (!rst_n)
                          s_q.done |=> s_q.done); // R4

endmodule

// File: rtl/mon_vector_remap.sv
module mon_vector_remap #(
    parameter int                ADDR_W    = 16,
    parameter int                VEC_BYTES = 4,
    parameter int                PAGE_BIT  = 8
) (
    input  logic              mon,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] vec_addr
);

    // The window is the top VEC_BYTES bytes of the address space.
    localparam int WIN_LSB = $clog2(VEC_BYTES);
    localparam int HI_W    = ADDR_W - WIN_LSB;

    logic in_window;
    logic remap;

    always_comb begin
        in_window = (fetch_addr[ADDR_W-1:WIN_LSB] == {HI_W{1'b1}});
        remap     = mon && in_window;
    end

    // Clear the page bit for remapped fetches; all other bits pass through.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b == PAGE_BIT) begin : g_page
            assign vec_addr[b] = fetch_addr[b] && !remap;
        end else begin : g_pass
            assign vec_addr[b] = fetch_addr[b];
        end
    end

endmodule

// File: rtl/mon_cop_gate.sv
module mon_cop_gate
    import mon_entry_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic mon,
    input  logic hv_entry,
    input  logic hv_present,
    input  logic cop_dis,
    output logic cop_en
);

    cop_st c_d, c_q;
    logic  cop_req;

    always_comb begin
        c_d = c_q;
        if (done && mon && hv_entry && !hv_present) begin
            c_d.hv_lost = 1'b1;
        end
        cop_req = done && (!mon || c_q.hv_lost);
        cop_en  = cop_req && !cop_dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    AST_LOSS_CAUSE:  assert property (@(posedge clk) disable iff (!rst_n)
                         $rose(c_q.hv_lost) |-> $past(!hv_present)); // R11
    AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                         c_q.hv_lost |=> c_q.hv_lost); // R11
    AST_MON_COP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                         (mon && !c_q.hv_lost) |-> !cop_en); // R10

endmodule

// File: rtl/monitor_entry_ctrl.sv
module monitor_entry_ctrl #(
    parameter int               ADDR_W     = 16,
    parameter int               DATA_W     = 8,
    parameter int               MODE_W     = 2,
    parameter logic [MODE_W-1:0] MODE_MATCH = 2'b10,
    parameter int               VEC_BYTES  = 4,
    parameter int               PAGE_BIT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_irq,
    input  logic              hv_rst,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              clk_sel,
    input  logic [DATA_W-1:0] rv_hi,
    input  logic [DATA_W-1:0] rv_lo,
    input  logic              cop_dis,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              mon_mode,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              clk_bypass,
    output logic              cop_en
);

    localparam int WIN_LSB = $clog2(VEC_BYTES);
    localparam int HI_W    = ADDR_W - WIN_LSB;

    logic hv_present;
    logic done;
    logic hv_entry;

    assign hv_present = hv_irq || hv_rst;

    mon_mode_sampler #(
        .MODE_W     (MODE_W),
        .MODE_MATCH (MODE_MATCH),
        .DATA_W     (DATA_W)
    ) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .hv_irq     (hv_irq),
        .hv_present (hv_present),
        .mode_pins  (mode_pins),
        .clk_sel    (clk_sel),
        .rv_hi      (rv_hi),
        .rv_lo      (rv_lo),
        .done       (done),
        .mon        (mon_mode),
        .bypass     (clk_bypass),
        .hv_entry   (hv_entry)
    );

    mon_vector_remap #(
        .ADDR_W     (ADDR_W),
        .VEC_BYTES  (VEC_BYTES),
        .PAGE_BIT   (PAGE_BIT)
    ) u_remap (
        .mon        (mon_mode),
        .fetch_addr (fetch_addr),
        .vec_addr   (vec_addr)
    );

    mon_cop_gate u_cop (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .mon        (mon_mode),
        .hv_entry   (hv_entry),
        .hv_present (hv_present),
        .cop_dis    (cop_dis),
        .cop_en     (cop_en)
    );

    AST_USER_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
                           !mon_mode |-> (vec_addr == fetch_addr)); // R6
    AST_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
                           (fetch_addr[ADDR_W-1:WIN_LSB] != {HI_W{1'b1}}) |-> (vec_addr == fetch_addr)); // R8
    AST_CFG_COP_OFF:   assert property (@(posedge clk) disable iff (!rst_n)
                           cop_dis |-> !cop_en); // R12
    AST_USER_COP_ON:   assert property (@(posedge clk) disable iff (!rst_n)
                           ($past(rst_n) && !$past(mon_mode) && $stable(mon_mode) && !mon_mode && !cop_dis && $past(mon_mode == mon_mode))
                           |-> (cop_en || !u_sampler.done)); // R10

endmodule

// File: tb/monitor_entry_ctrl_bench.sv
module monitor_entry_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv_irq = 1'b0;
    logic        hv_rst = 1'b0;
    logic [1:0]  mode_pins = 2'b00;
    logic        clk_sel = 1'b1;
    logic [7:0]  rv_hi = 8'h12;
    logic [7:0]  rv_lo = 8'h34;
    logic        cop_dis = 1'b0;
    logic [15:0] fetch_addr = 16'h0000;
    logic        mon_mode;
    logic [15:0] vec_addr;
    logic        clk_bypass;
    logic        cop_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    monitor_entry_ctrl u_monitor_entry_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hv_irq     (hv_irq),
        .hv_rst     (hv_rst),
        .mode_pins  (mode_pins),
        .clk_sel    (clk_sel),
        .rv_hi      (rv_hi),
        .rv_lo      (rv_lo),
        .cop_dis    (cop_dis),
        .fetch_addr (fetch_addr),
        .mon_mode   (mon_mode),
        .vec_addr   (vec_addr),
        .clk_bypass (clk_bypass),
        .cop_en     (cop_en)
    );

    // hv_irq, hv_rst, mode, clk_sel, rv_hi, rv_lo, exp_mon, exp_bypass
    typedef struct packed {
        logic       hvi;
        logic       hvr;
        logic [1:0] mode;
        logic       sel;
        logic [7:0] hi;
        logic [7:0] lo;
        logic       e_mon;
        logic       e_byp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 2'b10, 1'b1, 8'h12, 8'h34, 1'b1, 1'b0},  // R1 hv entry, divide
        '{1'b1, 1'b0, 2'b10, 1'b0, 8'h12, 8'h34, 1'b1, 1'b1},  // R1 R9 hv entry, bypass
        '{1'b1, 1'b0, 2'b01, 1'b0, 8'h12, 8'h34, 1'b0, 1'b0},  // R3 wrong mode pins
        '{1'b0, 1'b0, 2'b10, 1'b0, 8'h12, 8'h34, 1'b0, 1'b0},  // R3 no hv
        '{1'b0, 1'b0, 2'b00, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b0},  // R2 erased
        '{1'b0, 1'b0, 2'b00, 1'b0, 8'hFF, 8'hFF, 1'b1, 1'b1},  // R2 R9 erased, bypass
        '{1'b0, 1'b0, 2'b00, 1'b0, 8'hFF, 8'h7F, 1'b0, 1'b0},  // R2 low byte programmed
        '{1'b0, 1'b0, 2'b00, 1'b0, 8'h7F, 8'hFF, 1'b0, 1'b0},  // R2 high byte programmed
        '{1'b1, 1'b1, 2'b11, 1'b1, 8'hFF, 8'hFF, 1'b1, 1'b0}   // R2 erased with hv
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reset, apply pins, release, let one capture edge pass, sample at negedge.
    task automatic boot(input logic hvi, input logic hvr, input logic [1:0] md,
                        input logic sel, input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        rst_n = 1'b0;
        hv_irq = hvi; hv_rst = hvr; mode_pins = md; clk_sel = sel;
        rv_hi = hi; rv_lo = lo; cop_dis = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic chk_addr(input string req, input logic [15:0] a, input logic [15:0] e);
        fetch_addr = a;
        #1;
        chk(req, {16'h0, vec_addr}, {16'h0, e});
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset state with monitor-entry pins applied (R5)
        hv_irq = 1'b1; mode_pins = 2'b10; clk_sel = 1'b0; rv_hi = 8'hFF; rv_lo = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R5 mon_mode in reset", {31'h0, mon_mode}, 32'h0);
        chk("R5 clk_bypass in reset", {31'h0, clk_bypass}, 32'h0);
        chk("R5 cop_en in reset", {31'h0, cop_en}, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            boot(TBL[i].hvi, TBL[i].hvr, TBL[i].mode, TBL[i].sel, TBL[i].hi, TBL[i].lo);
            chk($sformatf("R1 R2 R3 mon_mode row %0d", i), {31'h0, mon_mode}, {31'h0, TBL[i].e_mon});
            chk($sformatf("R9 clk_bypass row %0d", i), {31'h0, clk_bypass}, {31'h0, TBL[i].e_byp});
            chk($sformatf("R10 cop_en row %0d", i), {31'h0, cop_en}, {31'h0, !TBL[i].e_mon});
            chk_addr($sformatf("R6 reset vector row %0d", i), 16'hFFFE,
                     TBL[i].e_mon ? 16'hFEFE : 16'hFFFE);
        end

        // R4: decision not visible before capture edge, held afterwards
        @(negedge clk);
        rst_n = 1'b0;
        hv_irq = 1'b1; hv_rst = 1'b0; mode_pins = 2'b10; clk_sel = 1'b0;
        rv_hi = 8'h12; rv_lo = 8'h34;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R4 mon_mode before capture edge", {31'h0, mon_mode}, 32'h0);
        @(negedge clk);
        chk("R4 mon_mode after capture edge", {31'h0, mon_mode}, 32'h1);
        hv_irq = 1'b0; mode_pins = 2'b00; clk_sel = 1'b1; rv_hi = 8'h00; rv_lo = 8'h00;
        repeat (4) @(negedge clk);
        chk("R4 mon_mode held", {31'h0, mon_mode}, 32'h1);
        chk("R4 clk_bypass held", {31'h0, clk_bypass}, 32'h1);
        // and user mode held against monitor-entry pins
        boot(1'b0, 1'b0, 2'b00, 1'b1, 8'h12, 8'h34);
        hv_irq = 1'b1; mode_pins = 2'b10; clk_sel = 1'b0; rv_hi = 8'hFF; rv_lo = 8'hFF;
        repeat (4) @(negedge clk);
        chk("R4 user mode held", {31'h0, mon_mode}, 32'h0);
        chk("R4 user bypass held", {31'h0, clk_bypass}, 32'h0);

        // R11: high voltage removed
        boot(1'b1, 1'b0, 2'b10, 1'b1, 8'h12, 8'h34);
        chk("R10 cop_en off while hv present", {31'h0, cop_en}, 32'h0);
        hv_irq = 1'b0;
        #1;
        chk("R11 cop_en before edge after drop", {31'h0, cop_en}, 32'h0);
        @(negedge clk);
        chk("R11 cop_en after hv drop", {31'h0, cop_en}, 32'h1);
        hv_irq = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 cop_en sticky after hv return", {31'h0, cop_en}, 32'h1);
        chk("R11 mode unchanged by hv drop", {31'h0, mon_mode}, 32'h1);
        // R12 gating while active in monitor
        cop_dis = 1'b1;
        #1;
        chk("R12 cop_dis in monitor", {31'h0, cop_en}, 32'h0);
        cop_dis = 1'b0;

        // R11: high voltage on reset pin keeps it present
        boot(1'b1, 1'b1, 2'b10, 1'b1, 8'h12, 8'h34);
        hv_irq = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 hv_rst keeps cop_en off", {31'h0, cop_en}, 32'h0);
        hv_rst = 1'b0;
        @(negedge clk);
        chk("R11 cop_en after both removed", {31'h0, cop_en}, 32'h1);

        // R10: erased-vector entry without high voltage keeps watchdog off
        boot(1'b0, 1'b0, 2'b00, 1'b1, 8'hFF, 8'hFF);
        repeat (5) @(negedge clk);
        chk("R10 erased entry cop_en off", {31'h0, cop_en}, 32'h0);

        // R12 in user mode
        boot(1'b0, 1'b0, 2'b00, 1'b1, 8'h12, 8'h34);
        chk("R10 user cop_en on", {31'h0, cop_en}, 32'h1);
        cop_dis = 1'b1;
        #1;
        chk("R12 cop_dis in user", {31'h0, cop_en}, 32'h0);
        cop_dis = 1'b0;
        #1;
        chk("R12 cop_en back", {31'h0, cop_en}, 32'h1);

        // User-mode vectors pass through
        chk_addr("R7 user FFFD", 16'hFFFD, 16'hFFFD);
        chk_addr("R7 user FFFC", 16'hFFFC, 16'hFFFC);
        chk_addr("R6 user FFFF", 16'hFFFF, 16'hFFFF);
        chk_addr("R8 user 1234", 16'h1234, 16'h1234);

        // Monitor-mode remap and boundaries
        boot(1'b1, 1'b0, 2'b10, 1'b1, 8'h12, 8'h34);
        chk_addr("R7 mon FFFC", 16'hFFFC, 16'hFEFC);
        chk_addr("R7 mon FFFD", 16'hFFFD, 16'hFEFD);
        chk_addr("R6 mon FFFE", 16'hFFFE, 16'hFEFE);
        chk_addr("R6 mon FFFF", 16'hFFFF, 16'hFEFF);
        chk_addr("R8 mon FFFB", 16'hFFFB, 16'hFFFB);
        chk_addr("R8 mon FEFE", 16'hFEFE, 16'hFEFE);
        chk_addr("R8 mon 7FFE", 16'h7FFE, 16'h7FFE);
        chk_addr("R8 mon 0000", 16'h0000, 16'h0000);
        chk_addr("R8 mon FDFF", 16'hFDFF, 16'hFDFF);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule